// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This unit performs the prefixed bit-manipulation group of an 8-bit processor on one byte. Each operation takes three inputs: the opcode byte that follows the prefix, the operand byte and the current flag byte. From these the unit returns four things:

- the new operand value;
- a write enable that says whether that value should go back to the register file;
- the new flag byte;
- a valid strobe.

The unit covers several operation classes:

- circular rotates;
- rotates through carry;
- arithmetic and logical shifts;
- the undocumented shift that inserts a one;
- bit test, bit clear and bit set.

The unit does not handle addressing, memory access or the register-select field. The caller fetches the operand and writes the result back to the register or memory location that the low three opcode bits name.

The work is done by combinational logic, and the outputs are registered. A request that is presented with `in_valid` high has its answer on the outputs one clock later. Between requests, the outputs keep their last values.

Top module: `rsb_unit`

## Requirements
- R1: While `rst` is high, at each clock edge `out_valid`, `wr_en`, `result` and `flags_out` become 0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and the outputs in that cycle belong to that request.
- R3: With `op_code[7:6]`=0 and `op_code[5:3]`=0 (rotate left circular), bit 7 moves to bit 0. With `op_code[5:3]`=1 (rotate right circular), bit 0 moves to bit 7. In both cases the bit that moved also goes to the carry flag.
- R4: With `op_code[5:3]`=2 (rotate left through carry) and 3 (rotate right through carry), the byte and the carry form a 9-bit ring. The incoming carry fills the vacated bit, and the bit pushed out becomes the new carry.
- R5: With `op_code[5:3]`=4 (left shift), a 0 enters at bit 0. With 7 (logical right shift), a 0 enters at bit 7. In both cases the carry receives the bit that left.
- R6: With `op_code[5:3]`=5 (arithmetic right shift), bit 7 is kept, which halves a signed value. With 6 (left shift inserting one), a 1 enters at bit 0. In both cases the carry receives the bit that left.
- R7: For every operation of class 0, `wr_en` is 1 and the flags are updated as follows:
  - bit 7 (sign) is copied from result bit 7;
  - bit 6 (zero) is set when the result is 0;
  - bit 4 (half-carry) is cleared;
  - bit 2 (parity) is 1 when the result has an even number of ones;
  - bit 1 (subtract) is cleared;
  - flag bits 5 and 3 are copied from `flags_in`.
- R8: For `op_code[7:6]`=1 (test of bit `op_code[5:3]`), `wr_en` is 0 and `result` equals the operand. The flags are as follows:
  - zero and parity are both set when the tested bit is 0;
  - half-carry is 1 and subtract is 0;
  - sign is 1 only when the index is 7 and the tested bit is 1;
  - carry and bits 5 and 3 are copied from `flags_in`.
- R9: For `op_code[7:6]`=2 (clear bit) and 3 (set bit), `wr_en` is 1 and only the indexed bit changes, to 0 or to 1 respectively. `flags_out` equals `flags_in`.
- R10: In a cycle after one with `in_valid` low, `result`, `wr_en` and `flags_out` hold their previous values and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_code | input | 8 | Opcode byte after the prefix |
| operand | input | W | Operand byte |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Answer strobe, one cycle after the request |
| result | output | W | New operand value |
| wr_en | output | 1 | Result must be written back |
| flags_out | output | 8 | New flag byte |

## Verification
The bench runs every one of the 256 opcodes against operands chosen to hit the edge bits: 0x00, 0x80, 0x01, 0xFF and mixed patterns. It does so with the incoming flag byte both all-zero and all-one, so that a swapped rotate direction, a ring that drops the carry, or an arithmetic shift that clears bit 7 shows up as a wrong result or a wrong carry. The flag byte also exposes a bit test that raises sign for indexes other than 7, a set or clear that disturbs the flags, and a test that writes back. Idle gaps between requests catch outputs that drift when no request is present.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int FLAG_W = 8;
  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_H  = 4;
  localparam int F_PV = 2;
  localparam int F_N  = 1;
  localparam int F_C  = 0;

  typedef enum logic [2:0] {
    SH_ROL_CIRC = 3'd0,
    SH_ROR_CIRC = 3'd1,
    SH_ROL_CARRY = 3'd2,
    SH_ROR_CARRY = 3'd3,
    SH_LEFT_ZERO = 3'd4,
    SH_RIGHT_SIGN = 3'd5,
    SH_LEFT_ONE = 3'd6,
    SH_RIGHT_ZERO = 3'd7
  } shift_kind_e;

  typedef enum logic [1:0] {
    CL_SHIFT = 2'd0,
    CL_TEST  = 2'd1,
    CL_CLEAR = 2'd2,
    CL_SET   = 2'd3
  } op_class_e;
endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_kind_e  kind,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    res  = a;
    cout = 1'b0;
    case (kind)
      SH_ROL_CIRC:   begin res = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
      SH_ROR_CIRC:   begin res = {a[0], a[W-1:1]};   cout = a[0];   end
      SH_ROL_CARRY:  begin res = {a[W-2:0], cin};    cout = a[W-1]; end
      SH_ROR_CARRY:  begin res = {cin, a[W-1:1]};    cout = a[0];   end
      SH_LEFT_ZERO:  begin res = {a[W-2:0], 1'b0};   cout = a[W-1]; end
      SH_RIGHT_SIGN: begin res = {a[W-1], a[W-1:1]}; cout = a[0];   end
      SH_LEFT_ONE:   begin res = {a[W-2:0], 1'b1};   cout = a[W-1]; end
      default:       begin res = {1'b0, a[W-1:1]};   cout = a[0];   end
    endcase
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  op_class_e     cls,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  a,
  output logic [W-1:0]  res,
  output logic          tested
);
  logic [W-1:0] mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (idx == IW'(i));
  end

  always_comb begin
    case (cls)
      CL_CLEAR: res = a & ~mask;
      CL_SET:   res = a | mask;
      default:  res = a;
    endcase
  end

  assign tested = |(a & mask);
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        op_code,
  input  logic [W-1:0]      operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              wr_en,
  output logic [FLAG_W-1:0] flags_out
);
  op_class_e    cls;
  shift_kind_e  kind;
  logic [W-1:0] sh_res, bit_res, nxt_res;
  logic         sh_cout, tested, nxt_wr;
  logic [FLAG_W-1:0] nxt_flags;

  assign cls  = op_class_e'(op_code[7:6]);
  assign kind = shift_kind_e'(op_code[5:3]);

  rsb_shift #(.W(W)) u_shift (
    .kind(kind), .a(operand), .cin(flags_in[F_C]),
    .res(sh_res), .cout(sh_cout)
  );

  rsb_bitop #(.W(W)) u_bitop (
    .cls(cls), .idx(op_code[3+IW-1:3]), .a(operand),
    .res(bit_res), .tested(tested)
  );

  always_comb begin
    nxt_flags = flags_in;
    nxt_res   = bit_res;
    nxt_wr    = 1'b1;
    case (cls)
      CL_SHIFT: begin
        nxt_res         = sh_res;
        nxt_flags[F_S]  = sh_res[W-1];
        nxt_flags[F_Z]  = (sh_res == '0);
        nxt_flags[F_H]  = 1'b0;
        nxt_flags[F_PV] = ~^sh_res;
        nxt_flags[F_N]  = 1'b0;
        nxt_flags[F_C]  = sh_cout;
      end
      CL_TEST: begin
        nxt_wr          = 1'b0;
        nxt_flags[F_S]  = tested && (op_code[3+IW-1:3] == IW'(W-1));
        nxt_flags[F_Z]  = ~tested;
        nxt_flags[F_H]  = 1'b1;
        nxt_flags[F_PV] = ~tested;
        nxt_flags[F_N]  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        wr_en     <= nxt_wr;
        flags_out <= nxt_flags;
      end
    end
  end
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk
  import rsb_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        op_code,
  input logic [W-1:0]      operand,
  input logic [FLAG_W-1:0] flags_in,
  input logic              out_valid,
  input logic [W-1:0]      result,
  input logic              wr_en,
  input logic [FLAG_W-1:0] flags_out
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(flags_out) && $stable(wr_en))); // R10

  AST_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_code[7:6]) == 2'd0)
      |-> (wr_en && !flags_out[F_H] && !flags_out[F_N])); // R7

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_code[7:6]) == 2'd1)
      |-> (!wr_en && flags_out[F_H] && result == $past(operand))); // R8

  AST_SETCLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_code[7]))
      |-> (wr_en && flags_out == $past(flags_in))); // R9
endmodule

bind rsb_unit rsb_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
  .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
  .result(result), .wr_en(wr_en), .flags_out(flags_out)
);

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] op_code = '0;
  logic [7:0] operand = '0;
  logic [7:0] flags_in = '0;
  logic       out_valid, wr_en;
  logic [7:0] result, flags_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference state
  int  e_valid = 0, e_res = 0, e_wr = 0, e_flags = 0;
  string e_tag_res = "R1", e_tag_flg = "R1";

  always #2 clk = ~clk;

  rsb_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  // behavioural reference model, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      e_valid <= 0; e_res <= 0; e_wr <= 0; e_flags <= 0;
      e_tag_res <= "R1"; e_tag_flg <= "R1";
    end else begin
      e_valid <= in_valid ? 1 : 0;
      if (in_valid) begin
        int v, f, cls, sel, r, c, nf, bitv;
        v = operand; f = flags_in; cls = op_code / 64; sel = (op_code / 8) % 8;
        nf = f;
        if (cls == 0) begin
          case (sel)
            0: begin r = ((v * 2) + (v / 128)) % 256; c = v / 128; end
            1: begin r = (v / 2) + (v % 2) * 128;     c = v % 2;   end
            2: begin r = ((v * 2) + (f % 2)) % 256;   c = v / 128; end
            3: begin r = (v / 2) + (f % 2) * 128;     c = v % 2;   end
            4: begin r = (v * 2) % 256;               c = v / 128; end
            5: begin r = (v / 2) + (v / 128) * 128;   c = v % 2;   end
            6: begin r = ((v * 2) % 256) + 1;         c = v / 128; end
            default: begin r = v / 2;                 c = v % 2;   end
          endcase
          nf = (f & 8'h28) | ((r / 128) * 128) | ((r == 0) ? 64 : 0)
             | ((ones(r) % 2 == 0) ? 4 : 0) | c;
          e_res <= r; e_wr <= 1; e_flags <= nf;
          e_tag_flg <= "R7";
          if (sel < 2) e_tag_res <= "R3";
          else if (sel < 4) e_tag_res <= "R4";
          else if (sel == 4 || sel == 7) e_tag_res <= "R5";
          else e_tag_res <= "R6";
        end else if (cls == 1) begin
          bitv = (v >> sel) & 1;
          nf = (f & 8'h29) | 16 | ((bitv == 0) ? 64 + 4 : 0)
             | ((sel == 7 && bitv == 1) ? 128 : 0);
          e_res <= v; e_wr <= 0; e_flags <= nf;
          e_tag_res <= "R8"; e_tag_flg <= "R8";
        end else begin
          if (cls == 2) r = v & ~(1 << sel) & 255;
          else r = v | (1 << sel);
          e_res <= r; e_wr <= 1; e_flags <= f;
          e_tag_res <= "R9"; e_tag_flg <= "R9";
        end
      end else begin
        e_tag_res <= "R10"; e_tag_flg <= "R10";
      end
    end
  end

  // compare away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      if (cycles > 1) begin
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "result", int'(result), 0);
        chk("R1", "wr_en", int'(wr_en), 0);
        chk("R1", "flags_out", int'(flags_out), 0);
      end
    end else begin
      chk(e_valid != 0 ? "R2" : "R10", "out_valid", int'(out_valid), e_valid);
      chk(e_tag_res, "result", int'(result), e_res);
      chk(e_tag_res, "wr_en", int'(wr_en), e_wr);
      chk(e_tag_flg, "flags_out", int'(flags_out), e_flags);
    end
  end

  initial begin
    automatic int pats[8] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'hA5, 8'h5A, 8'h7F, 8'h3C};
    automatic int n = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int fl = 0; fl < 2; fl++) begin
      for (int op = 0; op < 256; op++) begin
        for (int p = 0; p < 8; p++) begin
          @(negedge clk);
          n++;
          if (n % 7 == 0) begin
            in_valid = 1'b0;
            op_code  = 8'hC7;
            operand  = 8'h55;
            flags_in = 8'h00;
          end else begin
            in_valid = 1'b1;
            op_code  = 8'(op);
            operand  = 8'(pats[p]);
            flags_in = (fl == 0) ? 8'h00 : 8'hFF;
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule